// File: doc/BRIEF.md
# Iterative Half-Adder Feedback Adder

This block adds two unsigned operands without a full-adder carry chain. A single row of half adders works on two register words. On every clock it forms a bitwise partial sum (XOR) and a bitwise carry (AND). The partial sum goes back into the first register. The carry word, moved up one bit with a zero entering bit 0, goes back into the second register. The process repeats until the carry word is entirely zero, and the first register then holds the result. The number of passes depends on the data: it is small for typical operands, and a carry that has to cross the whole word costs one pass per bit.

A caller places the operands on the inputs and pulls the active-low start line from high to low. A 2:1 multiplexer in front of each register bit chooses the external operands on the launch cycle and the fed-back words after that. A tree of 4-input OR stages watches the carry word. When the tree reports zero, the active-low finish flag drops and the sum and the pass count are held steady until the next start edge. A carry that leaves the top bit position is kept as an extra sum bit and never re-enters the loop.

Top module: `iter_ha_adder`

## Requirements
- R1: While reset is held and in the cycle after it is released, finish_n is 1, iter_cnt is 0 and sum is 0.
- R2: A falling edge on start_n seen while idle launches an operation: at the next clock the operands are captured, and from then until the first pass completes finish_n reads 1 and iter_cnt reads 0.
- R3: When finish_n is 0, sum equals op_a + op_b as an unsigned WIDTH+1 bit value, for the operands captured at launch.
- R4: iter_cnt equals the number of passes P of the recurrence c = x AND y, x = x XOR y, y = (c shifted left by one, bit 0 zero, bits above WIDTH-1 dropped), counted up to and including the first pass that yields c = 0. Examples: 011111 + 000001 on a 6-bit word gives 6, and 000000 + 000000 gives 1.
- R5: Counting the launch clock edge as edge 0, finish_n is 1 after edges 1 to P-1 and becomes 0 after edge P.
- R6: A falling edge on start_n while an operation is running is ignored: the result and the pass count are those of the operands captured at launch.
- R7: After completion, sum, iter_cnt and finish_n stay unchanged until the next falling edge of start_n. Keeping start_n low, or changing op_a and op_b, has no effect.
- R8: A carry out of bit WIDTH-1 is stored in sum[WIDTH] and never fed back. All-ones plus one takes WIDTH+1 passes and gives 2^WIDTH.
- R9: Operands whose bitwise AND is zero complete after exactly one pass, with iter_cnt = 1 and sum = op_a OR op_b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_n | input | 1 | Start request; a falling edge launches an addition |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| sum | output | WIDTH+1 | Result including carry out |
| finish_n | output | 1 | Low once the carry word has reached zero |
| iter_cnt | output | cnt_width(WIDTH) | Number of half-adder passes of the last operation |

## Verification
The hardest state to reach is a carry that runs through every bit and then out of the top of the word. Only operand pairs such as all-ones plus one produce it, and only they drive the pass count to its maximum of WIDTH+1. The bench sweeps every operand pair of a 6-bit instance, so every carry pattern, including that run, occurs. For each pair it also measures the cycle in which finish_n drops. Intrusions on a busy operation are timed with a slow operand pair, so the second start edge lands while passes remain.

// File: rtl/iha_pkg.sv
// Shared definitions for the iterative half-adder adder.
// Assumes WIDTH >= 2 for every user of cnt_width.
package iha_pkg;

    // Controller phase: waiting for a start edge, or iterating
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;

    // Counter width able to hold WIDTH+1 passes
    function automatic int cnt_width(input int width);
        return $clog2(width + 2);
    endfunction

endpackage

// File: rtl/iha_ha_row.sv
// Row of WIDTH independent half adders.
// Purely combinational; bit i sees only bit i of both words.
module iha_ha_row #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    output logic [WIDTH-1:0] s_o,
    output logic [WIDTH-1:0] c_o
);

    // One half adder per bit position
    for (genvar i = 0; i < WIDTH; i++) begin : g_ha
        assign s_o[i] = x_i[i] ^ y_i[i];
        assign c_o[i] = x_i[i] & y_i[i];
    end

endmodule

// File: rtl/iha_or4_tree.sv
// OR reduction built from 4-input OR stages, recursing until at most
// four signals remain. Unused inputs of a partial group are tied to 0.
module iha_or4_tree #(
    parameter int N = 8
) (
    input  logic [N-1:0] bits_i,
    output logic         any_o
);

    if (N <= 4) begin : g_leaf
        // Final stage: a single 4-input (or narrower) OR
        assign any_o = |bits_i;
    end else begin : g_stage
        localparam int GROUPS = (N + 3) / 4;
        localparam int PADDED = GROUPS * 4;

        logic [PADDED-1:0] padded;
        logic [GROUPS-1:0] grp_any;

        // Zero-extend to a whole number of groups
        always_comb begin
            padded         = '0;
            padded[N-1:0]  = bits_i;
        end

        // One 4-input OR per group
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            assign grp_any[g] = |padded[4*g +: 4];
        end

        iha_or4_tree #(
            .N(GROUPS)
        ) u_next (
            .bits_i (grp_any),
            .any_o  (any_o)
        );
    end

endmodule

// File: rtl/iha_fb_regs.sv
// Operand registers with a 2:1 select per bit between the external
// operands (on load) and the fed-back half-adder outputs (on step).
// The carry word re-enters shifted up one place with 0 in bit 0; the
// carry leaving bit WIDTH-1 is accumulated into top_o instead.
module iha_fb_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] ext_x_i,
    input  logic [WIDTH-1:0] ext_y_i,
    input  logic [WIDTH-1:0] s_i,
    input  logic [WIDTH-1:0] c_i,
    output logic [WIDTH-1:0] x_o,
    output logic [WIDTH-1:0] y_o,
    output logic             top_o
);

    logic [WIDTH-1:0] x_nxt;
    logic [WIDTH-1:0] y_nxt;
    logic [WIDTH-1:0] c_up;

    assign c_up = {c_i[WIDTH-2:0], 1'b0};

    // Per-bit operand/feedback multiplexers
    for (genvar i = 0; i < WIDTH; i++) begin : g_mux
        assign x_nxt[i] = load_i ? ext_x_i[i] : s_i[i];
        assign y_nxt[i] = load_i ? ext_y_i[i] : c_up[i];
    end

    // Capture operands on load, feedback words on each step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o   <= '0;
            y_o   <= '0;
            top_o <= 1'b0;
        end else if (load_i) begin
            x_o   <= x_nxt;
            y_o   <= y_nxt;
            top_o <= 1'b0;
        end else if (step_i) begin
            x_o   <= x_nxt;
            y_o   <= y_nxt;
            top_o <= top_o | c_i[WIDTH-1];
        end
    end

    // The sum fits WIDTH+1 bits, so a second carry-out cannot occur
    AST_TOP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && top_o) |-> !c_i[WIDTH-1]); // R8

endmodule

// File: rtl/iter_ha_adder.sv
// Iterative adder: one half-adder pass per clock, feedback until the
// carry word is zero. Launch on a falling start_n edge while idle;
// finish_n drops when the OR tree sees an all-zero carry word.
// Assumes WIDTH >= 2 and that operands are valid at the launch edge.
module iter_ha_adder #(
    parameter int WIDTH = 8,
    localparam int CNT_W = iha_pkg::cnt_width(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH:0]   sum,
    output logic             finish_n,
    output logic [CNT_W-1:0] iter_cnt
);
    import iha_pkg::*;

    phase_t           phase;
    logic             start_q;
    logic             start_fall;
    logic             launch;
    logic             step;
    logic [WIDTH-1:0] x_q;
    logic [WIDTH-1:0] y_q;
    logic             top_q;
    logic [WIDTH-1:0] s_w;
    logic [WIDTH-1:0] c_w;
    logic             carry_any;

    assign start_fall = start_q & ~start_n;
    assign launch     = start_fall & (phase == PH_IDLE);
    assign step       = (phase == PH_RUN);

    iha_fb_regs #(
        .WIDTH(WIDTH)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (launch),
        .step_i  (step),
        .ext_x_i (op_a),
        .ext_y_i (op_b),
        .s_i     (s_w),
        .c_i     (c_w),
        .x_o     (x_q),
        .y_o     (y_q),
        .top_o   (top_q)
    );

    iha_ha_row #(
        .WIDTH(WIDTH)
    ) u_row (
        .x_i (x_q),
        .y_i (y_q),
        .s_o (s_w),
        .c_o (c_w)
    );

    iha_or4_tree #(
        .N(WIDTH)
    ) u_done (
        .bits_i (c_w),
        .any_o  (carry_any)
    );

    // Remember start_n to find its falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) start_q <= 1'b1;
        else        start_q <= start_n;
    end

    // Phase, completion flag and pass counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            finish_n <= 1'b1;
            iter_cnt <= '0;
        end else if (launch) begin
            phase    <= PH_RUN;
            finish_n <= 1'b1;
            iter_cnt <= '0;
        end else if (step) begin
            iter_cnt <= iter_cnt + CNT_W'(1);
            if (!carry_any) begin
                phase    <= PH_IDLE;
                finish_n <= 1'b0;
            end
        end
    end

    assign sum = {top_q, x_q};

    AST_LAUNCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (finish_n && iter_cnt == '0)); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        iter_cnt <= CNT_W'(WIDTH + 1)); // R4

    AST_FINISH_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !carry_any) |=> !finish_n); // R5

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && start_fall) |=> (iter_cnt == $past(iter_cnt) + CNT_W'(1))); // R6

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!finish_n && !start_fall) |=> ($stable(sum) && $stable(iter_cnt) && !finish_n)); // R7

endmodule

// File: tb/iter_ha_adder_bench.sv
// Exhaustive bench on a 6-bit instance with arithmetic reference values.
module iter_ha_adder_bench;

    localparam int W  = 6;
    localparam int CW = iha_pkg::cnt_width(W);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_n = 1'b1;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [W:0]    sum;
    logic          finish_n;
    logic [CW-1:0] iter_cnt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    iter_ha_adder #(
        .WIDTH(W)
    ) u_iter_ha_adder (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_n  (start_n),
        .op_a     (op_a),
        .op_b     (op_b),
        .sum      (sum),
        .finish_n (finish_n),
        .iter_cnt (iter_cnt)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference pass count from the recurrence in the requirements
    function automatic int ref_passes(input int a, input int b);
        int x = a;
        int y = b;
        int c;
        int p = 0;
        int mask = (1 << W) - 1;
        do begin
            c = x & y;
            x = x ^ y;
            y = (c << 1) & mask;
            p++;
        end while (c != 0);
        return p;
    endfunction

    // Launch one addition, wait for completion, check the results
    task automatic run_op(input int a, input int b, input string req);
        int p = ref_passes(a, b);
        int k = 0;
        @(negedge clk);
        op_a = W'(a);
        op_b = W'(b);
        start_n = 1'b0;
        @(negedge clk);
        chk(finish_n == 1'b1 && iter_cnt == 0, "R2", "launch state",
            int'(iter_cnt), 0);
        start_n = 1'b1;
        while (finish_n && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk(k == p, "R5", $sformatf("%s latency %0d+%0d", req, a, b), k, p);
        chk(sum == (W+1)'(a + b), "R3", $sformatf("%s sum %0d+%0d", req, a, b),
            int'(sum), a + b);
        chk(int'(iter_cnt) == p, "R4", $sformatf("%s count %0d+%0d", req, a, b),
            int'(iter_cnt), p);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk(finish_n == 1'b1, "R1", "finish_n in reset", int'(finish_n), 1);
        chk(iter_cnt == 0 && sum == 0, "R1", "count/sum in reset", int'(sum), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(finish_n == 1'b1 && iter_cnt == 0 && sum == 0, "R1",
            "after release", int'(iter_cnt), 0);

        // R4 named examples
        run_op(31, 1, "R4");
        chk(int'(iter_cnt) == 6, "R4", "011111+000001 passes", int'(iter_cnt), 6);
        run_op(0, 0, "R4");
        chk(int'(iter_cnt) == 1, "R4", "zero+zero passes", int'(iter_cnt), 1);

        // R8: carry through every bit and out of the top
        run_op(63, 1, "R8");
        chk(int'(iter_cnt) == W + 1 && sum == 64, "R8", "all-ones+1",
            int'(iter_cnt), W + 1);
        run_op(63, 63, "R8");
        chk(sum[W] == 1'b1, "R8", "top bit 63+63", int'(sum[W]), 1);

        // R9: disjoint operands finish in one pass
        run_op(42, 21, "R9");
        chk(int'(iter_cnt) == 1 && sum == 63, "R9", "disjoint 42+21",
            int'(iter_cnt), 1);

        // R6: second start edge while busy
        begin
            int k = 0;
            @(negedge clk);
            op_a = 6'd63;
            op_b = 6'd1;
            start_n = 1'b0;
            @(negedge clk);
            start_n = 1'b1;
            @(negedge clk);
            k = 1;
            op_a = 6'd0;
            op_b = 6'd0;
            start_n = 1'b0;
            @(negedge clk);
            k = 2;
            start_n = 1'b1;
            while (finish_n && k < 40) begin
                @(negedge clk);
                k++;
            end
            chk(sum == 64, "R6", "sum after busy start", int'(sum), 64);
            chk(int'(iter_cnt) == 7 && k == 7, "R6", "count after busy start",
                int'(iter_cnt), 7);
        end

        // R7: operand changes after completion
        run_op(27, 14, "R7");
        @(negedge clk);
        op_a = 6'd5;
        op_b = 6'd9;
        repeat (4) @(negedge clk);
        chk(!finish_n && sum == 41 && int'(iter_cnt) == ref_passes(27, 14), "R7",
            "hold after operand change", int'(sum), 41);

        // R7: start_n kept low after launch does not relaunch
        begin
            int k = 0;
            int p = ref_passes(45, 19);
            @(negedge clk);
            op_a = 6'd45;
            op_b = 6'd19;
            start_n = 1'b0;
            @(negedge clk);
            while (finish_n && k < 40) begin
                @(negedge clk);
                k++;
            end
            repeat (4) @(negedge clk);
            chk(!finish_n && sum == 64 && int'(iter_cnt) == p, "R7",
                "hold with start low", int'(iter_cnt), p);
            start_n = 1'b1;
        end

        // R3/R4/R5: every operand pair
        for (int a = 0; a < (1 << W); a++) begin
            for (int b = 0; b < (1 << W); b++) begin
                run_op(a, b, "R3");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule